// File: doc/BRIEF.md
# Two-Phase Output Port Controller

This block sits at the output edge of a synchronous logic region and sends data words to a receiver over a transition-signalled, bundled-data channel. Every edge of the request line, rising or falling, announces a new word; the receiver answers each word with an edge of the same direction on its acknowledge line. No return-to-zero phase exists, so one transfer costs a single round trip on the wire.

The controller is demand-type. Once the logic asks for a send and the word goes out, a clock-pause request is raised towards the local clock generator. It stays high until the acknowledge, passed through a two-flop synchroniser, matches the request level. The driven word is frozen for that whole window. An acknowledge edge that arrives while nothing is outstanding changes no channel state and sets a sticky protocol-error flag.

Top module: `twophase_tx_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req`, `dout`, `pause_req` and `proto_err` are all 0.
- R2: On a rising clock edge where `send_en` is 1 and no transfer is outstanding (`pause_req` = 0), `req` inverts and `dout` takes the value of `din`.
- R3: `pause_req` is 1 from the edge on which `req` inverts until the acknowledge matches. After `ack_in` changes to the level of `req`, `pause_req` stays 1 after the first and second rising edges and is 0 after the third.
- R4: While `pause_req` is 1, `req` and `dout` keep their values whatever `send_en` and `din` do.
- R5: Successive words use opposite edges of `req`. The first word after reset drives `req` from 0 to 1, and the second drives it from 1 to 0.
- R6: With `send_en` at 0, `req` and `dout` do not change.
- R7: A change of `ack_in` while no transfer is outstanding leaves `req`, `dout` and `pause_req` unchanged. It sets `proto_err` to 1 after the third rising edge, and `proto_err` then stays 1 until reset.
- R8: With `send_en` held at 1 and the acknowledge returned at once, a new word goes out on the first rising edge after `pause_req` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock of the sending region |
| rst_n | input | 1 | Active-low synchronous reset |
| send_en | input | 1 | Logic asks to send `din` on the next edge |
| din | input | W | Word to be sent |
| ack_in | input | 1 | Transition-signalled acknowledge from the receiver (asynchronous) |
| req | output | 1 | Transition-signalled request, one edge per word |
| dout | output | W | Bundled data, stable while a word is outstanding |
| pause_req | output | 1 | Asks the clock generator to stretch the next edge |
| proto_err | output | 1 | Sticky flag: an acknowledge edge arrived with nothing outstanding |

## Verification
Two things can fall on the same rising edge: the matching acknowledge being accepted, and the logic's enable asking for the next word with fresh data. The bench holds `send_en` high with a changing `din` across the cycle in which `pause_req` falls. It expects `req` and `dout` to stay put on the accepting edge, and the new word to appear only one edge later. A stray acknowledge edge is also driven right after a completed transfer. The bench then checks that it raises the error flag without disturbing the idle channel outputs.

// File: rtl/twophase_tx_port.sv
module twophase_tx_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         send_en,
  input  logic [W-1:0] din,
  input  logic         ack_in,
  output logic         req,
  output logic [W-1:0] dout,
  output logic         pause_req,
  output logic         proto_err
);

  logic ack_m, ack_s, ack_d, ack_seen;
  logic pending, issue, accept, stray;

  assign pending   = req ^ ack_seen;
  assign issue     = send_en & ~pending;
  assign accept    = pending & (ack_s == req);
  assign stray     = (ack_s != ack_d) & ~pending;
  assign pause_req = pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_m     <= 1'b0;
      ack_s     <= 1'b0;
      ack_d     <= 1'b0;
      ack_seen  <= 1'b0;
      req       <= 1'b0;
      dout      <= '0;
      proto_err <= 1'b0;
    end else begin
      ack_m <= ack_in;
      ack_s <= ack_m;
      ack_d <= ack_s;
      if (issue) begin
        req  <= ~req;
        dout <= din;
      end
      if (accept) ack_seen <= ack_s;
      if (stray) proto_err <= 1'b1;
    end
  end

endmodule

module twophase_tx_port_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         send_en,
  input logic [W-1:0] din,
  input logic         req,
  input logic [W-1:0] dout,
  input logic         pause_req,
  input logic         proto_err
);

  assert_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && !pause_req) |=> (req != $past(req)) && (dout == $past(din)));

  assert_pause_on_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req) |-> pause_req);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> $stable(req) && $stable(dout));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !send_en |=> $stable(req) && $stable(dout));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind twophase_tx_port twophase_tx_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .send_en(send_en), .din(din), .req(req),
  .dout(dout), .pause_req(pause_req), .proto_err(proto_err)
);

// File: tb/twophase_tx_port_tb.sv
module twophase_tx_port_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         send_en = 1'b0;
  logic [W-1:0] din = '0;
  logic         ack_in = 1'b0;
  logic         req;
  logic [W-1:0] dout;
  logic         pause_req;
  logic         proto_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twophase_tx_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_en(send_en), .din(din), .ack_in(ack_in),
    .req(req), .dout(dout), .pause_req(pause_req), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic next_req(input logic cur);
    return ~cur;
  endfunction

  logic         exp_req;
  logic [W-1:0] exp_dout;

  task automatic send_word(input logic [W-1:0] w, input string tag);
    send_en = 1'b1;
    din = w;
    @(negedge clk);
    exp_req = next_req(exp_req);
    exp_dout = w;
    chk({tag, " req toggles"}, req, exp_req);
    chk({tag, " dout loaded"}, dout, exp_dout);
    chk("R3 pause raised", pause_req, 1'b1);
  endtask

  task automatic return_ack(input bit en_during);
    ack_in = exp_req;
    send_en = en_during;
    din = $urandom;
    @(negedge clk);
    chk("R3 pause after 1st edge", pause_req, 1'b1);
    din = $urandom;
    @(negedge clk);
    chk("R3 pause after 2nd edge", pause_req, 1'b1);
    chk("R4 req held", req, exp_req);
    din = $urandom;
    @(negedge clk);
    chk("R3 pause after 3rd edge", pause_req, 1'b0);
    chk("R4 req held at accept", req, exp_req);
    chk("R4 dout held at accept", dout, exp_dout);
  endtask

  initial begin
    exp_req = 1'b0;
    exp_dout = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 req in reset", req, 1'b0);
    chk("R1 dout in reset", dout, '0);
    chk("R1 pause in reset", pause_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", req, 1'b0);
    chk("R1 err after reset", proto_err, 1'b0);

    send_word(32'hA5A5_0001, "R5 first rising R2");
    chk("R5 first edge rising", req, 1'b1);
    for (int i = 0; i < 4; i++) begin
      send_en = i[0];
      din = $urandom;
      @(negedge clk);
      chk("R4 req stable while pending", req, exp_req);
      chk("R4 dout stable while pending", dout, exp_dout);
    end
    return_ack(1'b1);
    // R8: enable held through acceptance, word goes out next edge
    din = 32'h0BAD_F00D;
    @(negedge clk);
    exp_req = next_req(exp_req);
    exp_dout = 32'h0BAD_F00D;
    chk("R8 next word issued", req, exp_req);
    chk("R5 second edge falling", req, 1'b0);
    chk("R8 next dout", dout, exp_dout);
    return_ack(1'b0);

    // R6: enable low, nothing moves
    for (int i = 0; i < 3; i++) begin
      din = $urandom;
      @(negedge clk);
      chk("R6 req idle", req, exp_req);
      chk("R6 dout idle", dout, exp_dout);
    end

    // R7: stray acknowledge edge
    ack_in = ~ack_in;
    @(negedge clk);
    @(negedge clk);
    chk("R7 err not yet", proto_err, 1'b0);
    @(negedge clk);
    chk("R7 err raised", proto_err, 1'b1);
    chk("R7 req untouched", req, exp_req);
    chk("R7 dout untouched", dout, exp_dout);
    chk("R7 pause untouched", pause_req, 1'b0);
    ack_in = ~ack_in;
    repeat (4) @(negedge clk);
    chk("R7 err sticky", proto_err, 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err cleared by reset", proto_err, 1'b0);
    exp_req = 1'b0;
    exp_dout = '0;

    // constrained random transfers
    for (int n = 0; n < 200; n++) begin
      send_word($urandom, "R2 random");
      for (int d = 0; d < int'($urandom_range(0, 5)); d++) begin
        send_en = $urandom_range(0, 1);
        din = $urandom;
        @(negedge clk);
        chk("R4 random hold req", req, exp_req);
        chk("R4 random hold dout", dout, exp_dout);
      end
      return_ack(1'b0);
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
        din = $urandom;
        @(negedge clk);
        chk("R6 random idle", req, exp_req);
      end
    end
    chk("R7 no error in clean run", proto_err, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule